// File: doc/BRIEF.md
# DDR SDRAM Power-Up Command Sequencer

This block issues the power-up command script for a DDR or DDR2 memory device after a start pulse. For each step it raises exactly one bit of a one-hot command strobe for a single cycle, together with the mode-register payload that belongs to that command. It then waits a programmable number of cycles before it issues the next step. A strap input, sampled when the start pulse is accepted, selects the DDR2 script or the DDR1 script. The DDR2 script includes a pair of extended-mode writes that enter and then leave off-chip driver calibration.

When the last step's gap has elapsed, the block raises `done_o` and keeps it high until reset. In the same cycle it publishes the refresh configuration word and the two DQS tap settings. A second strap, also sampled at start, selects the refresh interval for a 25 MHz or a 40 MHz reference clock. A controller datapath elsewhere consumes these outputs. The sequencer itself does not drive the memory pins.

Top module: `ddr_init_seq`

## Requirements
- R1: `cmd_o` never has more than one bit set. The bit meanings are: bit0 mode register set, bit1 extended mode register set, bit2 auto refresh, bit3 precharge all, bit4 extended mode register 2 set, bit5 extended mode register 3 set.
- R2: With the DDR2 strap high, the script runs in this order (command:payload): precharge:0, EMR2:0, EMR3:0, EMR:0, MRS:0x100, precharge:0, refresh:0, refresh:0, MRS:0xA33, EMR:0x382, EMR:0x402.
- R3: With the DDR2 strap low, the script runs in this order: precharge:0, MRS:0x133, EMR:0x002, precharge:0, MRS:0x033.
- R4: Both straps are captured in the cycle the start pulse is accepted. Changing them later in the run has no effect on the script or on the refresh word.
- R5: The first strobe appears in the cycle after the clock edge that accepts `start_i`. Each later strobe follows the previous one after exactly `GAP_CYC` cycles.
- R6: The strobe that follows a DLL-reset mode write (payload 0x100 for DDR2, 0x133 for DDR1) comes `DLL_GAP_CYC` cycles after that write instead of `GAP_CYC` cycles.
- R7: `mode_o` is zero in every cycle in which `cmd_o` is zero.
- R8: `busy_o` is high from the first strobe until `done_o` rises. `done_o` rises `GAP_CYC` cycles after the last strobe and stays high until reset. No strobe is issued while `done_o` is high.
- R9: `refresh_cfg_o` is zero before done. From done on, bit14 is 1 and bits 9:0 hold 624 if the 40 MHz strap was high at start, or 390 otherwise. All other bits are 0.
- R10: `tap0_o` and `tap1_o` are zero before done. From done on they read 0x08 and 0x09.
- R11: A start pulse is ignored while the sequence runs and after done. The strobe pattern, `busy_o` and `done_o` are unaffected.
- R12: Out of reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| strap_ddr2_i | input | 1 | 1 selects the DDR2 script, 0 the DDR1 script |
| strap_ref40_i | input | 1 | 1 selects the 40 MHz refresh interval |
| cmd_o | output | 6 | One-hot single-cycle command strobe |
| mode_o | output | 13 | Mode payload, valid with the strobe |
| busy_o | output | 1 | Script in progress |
| done_o | output | 1 | Script complete, sticky until reset |
| refresh_cfg_o | output | 15 | Refresh enable bit and interval |
| tap0_o | output | 8 | DQS lane 0 tap setting |
| tap1_o | output | 8 | DQS lane 1 tap setting |

## Verification
The hardest case to reach from the ports is a start request or a strap change that arrives in the middle of a run. The sequencer has to ignore both, and it has to do so even during the long gap after the DLL reset. The stimulus therefore scatters start pulses and strap flips at random through every run, and again after done. It then compares every cycle's strobe, payload and status against a schedule the bench computes from the straps it drove at start. Directed runs cover both scripts with both reference settings.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;
  localparam int CMD_W   = 6;
  localparam int MODE_W  = 13;
  localparam int IDX_W   = 4;
  localparam int REF_W   = 15;
  localparam int REF_EN  = 14;
  localparam int REF_IW  = 10;

  localparam logic [CMD_W-1:0] C_MRS  = 6'b000001;
  localparam logic [CMD_W-1:0] C_EMR  = 6'b000010;
  localparam logic [CMD_W-1:0] C_AREF = 6'b000100;
  localparam logic [CMD_W-1:0] C_PALL = 6'b001000;
  localparam logic [CMD_W-1:0] C_EMR2 = 6'b010000;
  localparam logic [CMD_W-1:0] C_EMR3 = 6'b100000;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} seq_state_t;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [MODE_W-1:0] mode;
    logic              dll_rst;
  } step_t;

  function automatic step_t mk(input logic [CMD_W-1:0] c, input logic [MODE_W-1:0] m,
                               input logic d);
    step_t s;
    s.cmd = c; s.mode = m; s.dll_rst = d;
    return s;
  endfunction

  // DDR2 script, eleven entries
  function automatic step_t ddr2_step(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0:    return mk(C_PALL, 13'h000, 1'b0);
      4'd1:    return mk(C_EMR2, 13'h000, 1'b0);
      4'd2:    return mk(C_EMR3, 13'h000, 1'b0);
      4'd3:    return mk(C_EMR,  13'h000, 1'b0);
      4'd4:    return mk(C_MRS,  13'h100, 1'b1);
      4'd5:    return mk(C_PALL, 13'h000, 1'b0);
      4'd6:    return mk(C_AREF, 13'h000, 1'b0);
      4'd7:    return mk(C_AREF, 13'h000, 1'b0);
      4'd8:    return mk(C_MRS,  13'hA33, 1'b0);
      4'd9:    return mk(C_EMR,  13'h382, 1'b0);
      4'd10:   return mk(C_EMR,  13'h402, 1'b0);
      default: return mk('0, '0, 1'b0);
    endcase
  endfunction

  // DDR1 script, five entries
  function automatic step_t ddr1_step(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0:    return mk(C_PALL, 13'h000, 1'b0);
      4'd1:    return mk(C_MRS,  13'h133, 1'b1);
      4'd2:    return mk(C_EMR,  13'h002, 1'b0);
      4'd3:    return mk(C_PALL, 13'h000, 1'b0);
      4'd4:    return mk(C_MRS,  13'h033, 1'b0);
      default: return mk('0, '0, 1'b0);
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] script_last(input logic ddr2);
    return ddr2 ? 4'd10 : 4'd4;
  endfunction

  function automatic logic [REF_W-1:0] refresh_word(input logic ref40, input int lo,
                                                   input int hi);
    logic [REF_W-1:0] w;
    w = '0;
    w[REF_EN] = 1'b1;
    w[REF_IW-1:0] = ref40 ? hi[REF_IW-1:0] : lo[REF_IW-1:0];
    return w;
  endfunction
endpackage

// File: rtl/ddr_init_script.sv
module ddr_init_script
  import ddr_init_pkg::*;
(
  input  logic             sel_ddr2,
  input  logic [IDX_W-1:0] idx,
  output step_t            entry,
  output logic             is_last
);
  always_comb begin
    entry   = sel_ddr2 ? ddr2_step(idx) : ddr1_step(idx);
    is_last = (idx == script_last(sel_ddr2));
  end
endmodule

// File: rtl/ddr_gap_timer.sv
module ddr_gap_timer #(
  parameter int GAP_CYC     = 4,   // must be >= 2
  parameter int DLL_GAP_CYC = 10   // must be >= 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic long_gap,
  output logic expire
);
  localparam int MAX_GAP = (DLL_GAP_CYC > GAP_CYC) ? DLL_GAP_CYC : GAP_CYC;
  localparam int CNT_W   = $clog2(MAX_GAP + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= long_gap ? CNT_W'(DLL_GAP_CYC - 2) : CNT_W'(GAP_CYC - 2);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/ddr_post_cfg.sv
module ddr_post_cfg
  import ddr_init_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int TAP_W    = 8,
  parameter int TAP_BASE = 8,
  parameter int REF_LO   = 390,
  parameter int REF_HI   = 624
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        set,
  input  logic                        ref40,
  output logic [REF_W-1:0]            refresh_cfg,
  output logic [LANES-1:0][TAP_W-1:0] taps
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   refresh_cfg <= '0;
    else if (set) refresh_cfg <= refresh_word(ref40, REF_LO, REF_HI);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   taps[g] <= '0;
      else if (set) taps[g] <= TAP_W'(TAP_BASE + g);
    end
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int GAP_CYC     = 4,
  parameter int DLL_GAP_CYC = 10,
  parameter int TAP_W       = 8,
  parameter int TAP_BASE    = 8,
  parameter int REF_LO      = 390,
  parameter int REF_HI      = 624
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              strap_ddr2_i,
  input  logic              strap_ref40_i,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [REF_W-1:0]  refresh_cfg_o,
  output logic [TAP_W-1:0]  tap0_o,
  output logic [TAP_W-1:0]  tap1_o
);
  localparam int LANES = 2;

  seq_state_t       state;
  logic [IDX_W-1:0] idx;
  logic             sel_ddr2, sel_ref40;
  step_t            entry;
  logic             is_last, expire;
  logic             accept, step_adv, seq_finish, issuing;
  logic [LANES-1:0][TAP_W-1:0] taps;

  // named events used by the checker
  assign accept     = (state == ST_IDLE) && start_i;
  assign issuing    = (state == ST_ISSUE);
  assign step_adv   = (state == ST_WAIT) && expire && !is_last;
  assign seq_finish = (state == ST_WAIT) && expire && is_last;

  ddr_init_script u_script (
    .sel_ddr2 (sel_ddr2),
    .idx      (idx),
    .entry    (entry),
    .is_last  (is_last)
  );

  ddr_gap_timer #(.GAP_CYC(GAP_CYC), .DLL_GAP_CYC(DLL_GAP_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (issuing),
    .long_gap (entry.dll_rst),
    .expire   (expire)
  );

  ddr_post_cfg #(.LANES(LANES), .TAP_W(TAP_W), .TAP_BASE(TAP_BASE),
                 .REF_LO(REF_LO), .REF_HI(REF_HI)) u_post (
    .clk         (clk),
    .rst_n       (rst_n),
    .set         (seq_finish),
    .ref40       (sel_ref40),
    .refresh_cfg (refresh_cfg_o),
    .taps        (taps)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      sel_ddr2  <= 1'b0;
      sel_ref40 <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          sel_ddr2  <= strap_ddr2_i;
          sel_ref40 <= strap_ref40_i;
          idx       <= '0;
          state     <= ST_ISSUE;
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: begin
          if (seq_finish) state <= ST_DONE;
          else if (step_adv) begin
            idx   <= idx + 1'b1;
            state <= ST_ISSUE;
          end
        end
        ST_DONE: state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_o  = issuing ? entry.cmd  : '0;
  assign mode_o = issuing ? entry.mode : '0;
  assign busy_o = (state == ST_ISSUE) || (state == ST_WAIT);
  assign done_o = (state == ST_DONE);
  assign tap0_o = taps[0];
  assign tap1_o = taps[1];
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk
  import ddr_init_pkg::*;
#(
  parameter int TAP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [CMD_W-1:0]  cmd_o,
  input logic [MODE_W-1:0] mode_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [REF_W-1:0]  refresh_cfg_o,
  input logic [TAP_W-1:0]  tap0_o,
  input logic [TAP_W-1:0]  tap1_o,
  input logic              seq_finish,
  input logic              accept
);
  // R1
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cmd_o));
  // R7
  mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == '0) |-> (mode_o == '0));
  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != '0) |=> (cmd_o == '0));
  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> done_o);
  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && cmd_o == '0));
  // R8
  finish_done_chk: assert property (@(posedge clk) disable iff (!rst_n) seq_finish |=> done_o);
  // R9
  refresh_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o ? refresh_cfg_o[REF_EN] : (refresh_cfg_o == '0));
  // R10
  tap_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (tap1_o == tap0_o + 1'b1));
  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (busy_o || done_o)) |-> !accept);
endmodule

bind ddr_init_seq ddr_init_seq_chk #(.TAP_W(TAP_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .cmd_o         (cmd_o),
  .mode_o        (mode_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .refresh_cfg_o (refresh_cfg_o),
  .tap0_o        (tap0_o),
  .tap1_o        (tap1_o),
  .seq_finish    (seq_finish),
  .accept        (accept)
);

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;
  localparam int G = 4;
  localparam int D = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, strap_ddr2_i = 1'b0, strap_ref40_i = 1'b0;
  logic [5:0]  cmd_o;
  logic [12:0] mode_o;
  logic busy_o, done_o;
  logic [14:0] refresh_cfg_o;
  logic [7:0]  tap0_o, tap1_o;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ddr_init_seq #(.GAP_CYC(G), .DLL_GAP_CYC(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .strap_ddr2_i(strap_ddr2_i),
    .strap_ref40_i(strap_ref40_i), .cmd_o(cmd_o), .mode_o(mode_o), .busy_o(busy_o),
    .done_o(done_o), .refresh_cfg_o(refresh_cfg_o), .tap0_o(tap0_o), .tap1_o(tap1_o));

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // expected script: {cmd, mode}
  function automatic logic [18:0] exp_step(input bit ddr2, input int i);
    if (ddr2) begin
      case (i)
        0: return {6'h08, 13'h000};  1: return {6'h10, 13'h000};
        2: return {6'h20, 13'h000};  3: return {6'h02, 13'h000};
        4: return {6'h01, 13'h100};  5: return {6'h08, 13'h000};
        6: return {6'h04, 13'h000};  7: return {6'h04, 13'h000};
        8: return {6'h01, 13'hA33};  9: return {6'h02, 13'h382};
        default: return {6'h02, 13'h402};
      endcase
    end
    case (i)
      0: return {6'h08, 13'h000};  1: return {6'h01, 13'h133};
      2: return {6'h02, 13'h002};  3: return {6'h08, 13'h000};
      default: return {6'h01, 13'h033};
    endcase
  endfunction

  function automatic int gap_after(input bit ddr2, input int i);
    return ((ddr2 && i == 4) || (!ddr2 && i == 1)) ? D : G;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; start_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run(input bit ddr2, input bit ref40, input bit noisy);
    int nsteps, t, done_t;
    int at[11];
    string tg;
    nsteps = ddr2 ? 11 : 5;
    tg = ddr2 ? "R2" : "R3";
    t = 1;
    for (int i = 0; i < nsteps; i++) begin
      at[i] = t;
      t += gap_after(ddr2, i);
    end
    done_t = at[nsteps-1] + G;
    @(negedge clk);
    strap_ddr2_i = ddr2; strap_ref40_i = ref40; start_i = 1'b1;
    for (int cyc = 1; cyc <= done_t + 3; cyc++) begin
      logic [18:0] e;
      @(negedge clk);
      start_i = 1'b0;
      e = '0;
      for (int i = 0; i < nsteps; i++) if (at[i] == cyc) e = exp_step(ddr2, i);
      chk(tg, "cmd (R4 R5 R6 R11)", {26'd0, cmd_o}, {26'd0, e[18:13]});
      chk("R7", "mode", {19'd0, mode_o}, {19'd0, e[12:0]});
      chk("R1", "onehot", ($countones(cmd_o) <= 1), 1);
      chk("R8", "busy", busy_o, (cyc < done_t));
      chk("R8", "done", done_o, (cyc >= done_t));
      if (noisy) begin
        start_i       = ($urandom % 4) == 0;
        strap_ddr2_i  = $urandom % 2;
        strap_ref40_i = $urandom % 2;
      end
    end
    start_i = 1'b0;
    chk("R9", "refresh", {17'd0, refresh_cfg_o}, {17'd0, 15'h4000 | (ref40 ? 15'd624 : 15'd390)});
    chk("R10", "tap0", {24'd0, tap0_o}, 32'h08);
    chk("R10", "tap1", {24'd0, tap1_o}, 32'h09);
    // R11: start after done
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 2 * D; k++) begin
      @(negedge clk);
      chk("R11", "cmd after done", {26'd0, cmd_o}, 0);
      chk("R11", "done held", done_o, 1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R12
    chk("R12", "cmd", {26'd0, cmd_o}, 0);
    chk("R12", "mode", {19'd0, mode_o}, 0);
    chk("R12", "busy", busy_o, 0);
    chk("R12", "done", done_o, 0);
    chk("R12", "refresh", {17'd0, refresh_cfg_o}, 0);
    chk("R12", "taps", {16'd0, tap0_o, tap1_o}, 0);
    // R10/R9 before done: idle quiet
    repeat (5) @(negedge clk);
    chk("R9", "refresh idle", {17'd0, refresh_cfg_o}, 0);
    run(1'b1, 1'b0, 1'b0);
    do_reset();
    run(1'b0, 1'b1, 1'b0);
    for (int r = 0; r < 6; r++) begin
      bit d2, r40;
      d2 = $urandom % 2; r40 = $urandom % 2;
      do_reset();
      run(d2, r40, 1'b1);
    end
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule